// File: doc/BRIEF.md
# Memory-Mapped Register Bank with APB Slave Port

This block sits between an APB bus master and an IP core. It turns APB transfers into reads and writes of a small set of word-aligned registers. Each register has one of three access modes.

A write-only control register holds two enable bits, and each bit drives its own core input. A read-only capture register shows a 16-bit value that the core supplies. A split data register behaves differently in each direction. A bus write to it sets a set of output pins. A bus read of it returns the live state of a separate set of input pins, so the value read back need not match the value written.

The slave completes every transfer with no wait states and never signals an error. Read data comes straight from a combinational mux selected by the address. A write changes state on the clock edge that ends the access phase. Reset is synchronous and active-low.

Top module: `apb_reg_wrapper`

## Requirements
- R1: `pready` is 1 and `pslverr` is 0 in every cycle.
- R2: While `rst_n` is 0 at a rising edge, `pin_out`, `tmr_en` and `cnt_en` become 0 on that edge, and the control register then reads back as 0.
- R3: State changes only on an edge where `psel`, `penable` and `pwrite` are all 1. A setup phase, a read access, or `penable` high without `psel` leaves `pin_out`, `tmr_en` and `cnt_en` unchanged.
- R4: The control register sits at byte offset 12. Write data bit 0 sets `tmr_en` and bit 1 sets `cnt_en`, and higher bits are discarded. A read returns `{30'b0, cnt_en, tmr_en}`.
- R5: The capture register sits at byte offset 8. A read returns `cap_value` zero-extended to 32 bits. A write to it changes no output and no later read.
- R6: The split data register sits at byte offset 0. A write loads `pwdata[7:0]` into `pin_out`. A read returns `pin_in` zero-extended, whatever `pin_out` holds.
- R7: A read from any byte offset other than 0, 8 or 12 returns 0. A write to such an offset changes no output.
- R8: Address bits [1:0] play no part in decoding: byte addresses 1, 9 and 14 select the same registers as 0, 8 and 12.
- R9: Written values appear on `pin_out`, `tmr_en` and `cnt_en` in the cycle after the access-phase edge. `prdata` follows the address and the input pins in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| paddr | input | 8 | APB byte address |
| psel | input | 1 | APB slave select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB direction, 1 = write |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | Transfer ready, tied high |
| pslverr | output | 1 | Transfer error, tied low |
| cap_value | input | 16 | Value from the core shown by the capture register |
| pin_in | input | 8 | Input pins read through the data register |
| pin_out | output | 8 | Output pins driven by the data register |
| tmr_en | output | 1 | Timer enable, control bit 0 |
| cnt_en | output | 1 | Counter enable, control bit 1 |

## Verification
Faults in this block show up at the ports without delay:
- A wrong value in the data or control storage appears on `pin_out`, `tmr_en` or `cnt_en` in the cycle after the faulty write edge. The control fault also appears on the next read of offset 12.
- A decode fault shows on `prdata` in the same cycle the address is presented, because the read path holds no state.
- A write strobe that ignores `psel` or `penable` changes an output one cycle after a setup phase or a bare enable pulse.

The reference model is compared on every clock, so each of these faults is caught at the first cycle it occurs.

// File: rtl/apbw_pkg.sv
package apbw_pkg;

    localparam int ADDR_W   = 8;
    localparam int DATA_W   = 32;
    localparam int PIN_W    = 8;
    localparam int CAP_W    = 16;
    localparam int CTRL_W   = 2;
    localparam int WORD_LSB = 2;

    localparam int OFS_IO   = 0;
    localparam int OFS_CAP  = 8;
    localparam int OFS_CTRL = 12;

    localparam int FLD_TMR  = 0;
    localparam int FLD_CNT  = 1;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_IO,
        SEL_CAP,
        SEL_CTRL
    } reg_sel_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              sel;
        logic              enable;
        logic              write;
    } apb_req_t;

    function automatic reg_sel_e decode_offset(input logic [ADDR_W-1:0] a);
        logic [ADDR_W-1:0] word_addr;
        word_addr = {a[ADDR_W-1:WORD_LSB], {WORD_LSB{1'b0}}};
        if (word_addr == ADDR_W'(OFS_IO))
            return SEL_IO;
        else if (word_addr == ADDR_W'(OFS_CAP))
            return SEL_CAP;
        else if (word_addr == ADDR_W'(OFS_CTRL))
            return SEL_CTRL;
        else
            return SEL_NONE;
    endfunction

endpackage

// File: rtl/apbw_decode.sv
module apbw_decode
    import apbw_pkg::*;
(
    input  apb_req_t req,
    output reg_sel_e sel,
    output logic     wr_fire
);
    always_comb begin
        sel     = decode_offset(req.addr);
        wr_fire = req.sel & req.enable & req.write;
    end
endmodule

// File: rtl/apbw_wreg.sv
module apbw_wreg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (we)
            q <= d;
    end
endmodule

// File: rtl/apbw_rdmux.sv
module apbw_rdmux
    import apbw_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int PW = PIN_W,
    parameter int CW = CAP_W,
    parameter int KW = CTRL_W
) (
    input  reg_sel_e      sel,
    input  logic [PW-1:0] pin_in,
    input  logic [CW-1:0] cap_value,
    input  logic [KW-1:0] ctrl_q,
    output logic [DW-1:0] rdata
);
    always_comb begin
        unique case (sel)
            SEL_IO:   rdata = DW'(pin_in);
            SEL_CAP:  rdata = DW'(cap_value);
            SEL_CTRL: rdata = DW'(ctrl_q);
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/apb_reg_wrapper.sv
module apb_reg_wrapper
    import apbw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] paddr,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic              pready,
    output logic              pslverr,
    input  logic [CAP_W-1:0]  cap_value,
    input  logic [PIN_W-1:0]  pin_in,
    output logic [PIN_W-1:0]  pin_out,
    output logic              tmr_en,
    output logic              cnt_en
);
    apb_req_t          req;
    reg_sel_e          sel;
    logic              wr_fire;
    logic [CTRL_W-1:0] ctrl_q;

    assign req = '{addr: paddr, wdata: pwdata, sel: psel,
                   enable: penable, write: pwrite};

    assign pready  = 1'b1;
    assign pslverr = 1'b0;

    apbw_decode u_dec (
        .req     (req),
        .sel     (sel),
        .wr_fire (wr_fire)
    );

    apbw_wreg #(.W(PIN_W)) u_io (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_fire && sel == SEL_IO),
        .d     (req.wdata[PIN_W-1:0]),
        .q     (pin_out)
    );

    for (genvar f = 0; f < CTRL_W; f++) begin : g_ctrl_fld
        apbw_wreg #(.W(1)) u_fld (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (wr_fire && sel == SEL_CTRL),
            .d     (req.wdata[f]),
            .q     (ctrl_q[f])
        );
    end

    assign tmr_en = ctrl_q[FLD_TMR];
    assign cnt_en = ctrl_q[FLD_CNT];

    apbw_rdmux u_rd (
        .sel       (sel),
        .pin_in    (pin_in),
        .cap_value (cap_value),
        .ctrl_q    (ctrl_q),
        .rdata     (prdata)
    );
endmodule

// File: rtl/apbw_checker.sv
module apbw_checker
    import apbw_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] paddr,
    input logic              psel,
    input logic              penable,
    input logic              pwrite,
    input logic [DATA_W-1:0] pwdata,
    input logic [DATA_W-1:0] prdata,
    input logic              pready,
    input logic              pslverr,
    input logic [CAP_W-1:0]  cap_value,
    input logic [PIN_W-1:0]  pin_in,
    input logic [PIN_W-1:0]  pin_out,
    input logic              tmr_en,
    input logic              cnt_en
);
    logic [ADDR_W-1:0] waddr;
    logic              acc_wr;
    assign waddr  = {paddr[ADDR_W-1:WORD_LSB], {WORD_LSB{1'b0}}};
    assign acc_wr = psel && penable && pwrite;

    AST_READY_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        pready && !pslverr); // R1

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (pin_out == '0 && !tmr_en && !cnt_en)); // R2

    AST_NO_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_wr |=> ($stable(pin_out) && $stable(tmr_en) && $stable(cnt_en))); // R3

    AST_CTRL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr && waddr == ADDR_W'(OFS_CTRL)) |=>
        (tmr_en == $past(pwdata[0]) && cnt_en == $past(pwdata[1]))); // R4

    AST_CAP_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (waddr == ADDR_W'(OFS_CAP)) |-> (prdata == DATA_W'(cap_value))); // R5

    AST_IO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr && waddr == ADDR_W'(OFS_IO)) |=>
        (pin_out == $past(pwdata[PIN_W-1:0]))); // R6

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (waddr != ADDR_W'(OFS_IO) && waddr != ADDR_W'(OFS_CAP) &&
         waddr != ADDR_W'(OFS_CTRL)) |-> (prdata == '0)); // R7
endmodule

bind apb_reg_wrapper apbw_checker u_chk (.*);

// File: tb/tb_apb_reg_wrapper.sv
module tb_apb_reg_wrapper;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  paddr = '0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready, pslverr;
    logic [15:0] cap_value = '0;
    logic [7:0]  pin_in = '0;
    logic [7:0]  pin_out;
    logic        tmr_en, cnt_en;

    int    n_cmp = 0, n_bad = 0;
    bit    done = 0;
    string cur_req = "R2";

    // reference state
    logic [7:0] m_out  = '0;
    logic [1:0] m_ctrl = '0;

    always #2 clk = ~clk; // 250 MHz

    apb_reg_wrapper dut (.*);

    always @(posedge clk) begin
        if (!rst_n) begin
            m_out  <= '0;
            m_ctrl <= '0;
        end else if (psel && penable && pwrite) begin
            if ((paddr >> 2) == 0) m_out  <= pwdata[7:0];
            if ((paddr >> 2) == 3) m_ctrl <= pwdata[1:0];
        end
    end

    function automatic logic [31:0] exp_rd();
        int w = int'(paddr) / 4;
        if (w == 0) return {24'b0, pin_in};
        if (w == 2) return {16'b0, cap_value};
        if (w == 3) return {30'b0, m_ctrl};
        return 32'h0;
    endfunction

    task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
        end
    endtask

    // compare every clock, away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            chk("pready(R1)",  {31'b0, pready},  32'd1);
            chk("pslverr(R1)", {31'b0, pslverr}, 32'd0);
            chk("pin_out",     {24'b0, pin_out}, {24'b0, m_out});
            chk("tmr_en",      {31'b0, tmr_en},  {31'b0, m_ctrl[0]});
            chk("cnt_en",      {31'b0, cnt_en},  {31'b0, m_ctrl[1]});
            chk("prdata",      prdata,           exp_rd());
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        psel = 0; penable = 0; pwrite = 0;
        step();
    endtask

    task automatic xfer(logic [7:0] a, logic wr, logic [31:0] d);
        paddr = a; pwrite = wr; pwdata = d; psel = 1; penable = 0;
        step();
        penable = 1;
        step();
        psel = 0; penable = 0; pwrite = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // R2: reset state
        cur_req = "R2";
        repeat (3) step();
        rst_n = 1;
        cur_req = "R1";
        repeat (3) idle();

        // R6: data register write drives pins, read shows input pins
        cur_req = "R6";
        pin_in = 8'h3C;
        xfer(8'd0, 1, 32'hFFFF_FFA5);
        idle();
        xfer(8'd0, 0, 32'h0);
        pin_in = 8'hC3;
        idle();

        // R8: low address bits ignored
        cur_req = "R8";
        xfer(8'd1, 1, 32'h0000_005A);
        xfer(8'd14, 1, 32'h0000_0002);
        xfer(8'd9, 0, 32'h0);

        // R4: control fields
        cur_req = "R4";
        xfer(8'd12, 1, 32'hFFFF_FFFD);
        xfer(8'd12, 0, 32'h0);
        xfer(8'd12, 1, 32'h0000_0003);
        idle();

        // R5: capture is read-only
        cur_req = "R5";
        cap_value = 16'hBEEF;
        xfer(8'd8, 0, 32'h0);
        xfer(8'd8, 1, 32'hFFFF_FFFF);
        cap_value = 16'h1234;
        xfer(8'd8, 0, 32'h0);

        // R3: no write without full access phase
        cur_req = "R3";
        paddr = 8'd12; pwdata = 32'h0; pwrite = 1; psel = 1; penable = 0;
        step();
        psel = 0; penable = 1;
        step();
        paddr = 8'd0; pwdata = 32'h0;
        step();
        psel = 1; pwrite = 0;
        step();
        idle();

        // R7: unmapped offsets
        cur_req = "R7";
        xfer(8'd4, 1, 32'hFFFF_FFFF);
        xfer(8'd4, 0, 32'h0);
        xfer(8'd16, 1, 32'h0);
        xfer(8'hFC, 0, 32'h0);
        idle();

        // R2: reset mid-run clears outputs
        cur_req = "R2";
        xfer(8'd12, 1, 32'h3);
        rst_n = 0;
        step();
        rst_n = 1;
        xfer(8'd12, 0, 32'h0);

        // R9: mixed traffic, timing checked every clock
        cur_req = "R9";
        for (int i = 0; i < 300; i++) begin
            logic [7:0] a;
            a = 8'($urandom_range(0, 5) * 4 + $urandom_range(0, 3));
            pin_in    = 8'($urandom);
            cap_value = 16'($urandom);
            xfer(a, 1'($urandom), $urandom);
            if ($urandom_range(0, 3) == 0) idle();
        end
        idle();

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule